// File: doc/BRIEF.md
# Fixed-Priority DMA Bus Arbiter

This block sits between four DMA channels and the CPU and chooses which party drives the shared bus. Each channel raises a request line. Requests are collected over a sampling window that ends at a strobe. At that strobe every request seen during the window becomes a pending flag, all of them on the same clock edge. Each channel keeps one pending flag, so several requests from a channel before it is served lead to a single transfer.

When the bus is free to hand over, the lowest-numbered pending channel receives a one-hot grant. The grant lasts for exactly one transfer, which ends when the transfer-done input is seen. The bus then returns to the CPU. No further grant is issued until the CPU has reported one completed bus access. Granting a channel clears its pending flag. A request from that same channel that is sampled while its transfer runs sets the flag again. When nothing is pending, the CPU keeps the bus for as long as that lasts.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant_o` is 0 and `cpu_owns_o` is 1. Out of reset the CPU-access condition counts as already met, so the first grant needs no `cpu_done_i`.
- R2: A request bit seen on `req_i` in any cycle from the one after the previous strobe through the strobe cycle itself becomes pending at the edge where `sample_i` is high. Without a strobe nothing becomes pending and no grant follows.
- R3: Among pending channels the grant goes to the lowest index. Channel 0 is highest priority and channel 3 is lowest. Bit i of `grant_o` stands for channel i.
- R4: `grant_o` has at most one bit set, and `cpu_owns_o` is 1 exactly when `grant_o` is 0.
- R5: A grant stays unchanged until `xfer_done_i` is high. In the cycle after that, `grant_o` is 0 and `cpu_owns_o` is 1.
- R6: A channel's pending flag clears at the edge that grants it. Repeated requests from a channel before it is granted produce only one grant.
- R7: After a transfer ends, no grant is issued until `cpu_done_i` is seen high while the CPU owns the bus. A grant can be issued at that same edge, so it is visible in the next cycle.
- R8: A request from the granted channel that is sampled during its own transfer leaves that channel pending again, and it is granted again later.
- R9: With nothing pending, `cpu_owns_o` stays 1 and `grant_o` stays 0, whatever `cpu_done_i` does.
- R10: When the bus is eligible to hand over, the grant appears in the second cycle after the strobe cycle. The strobe edge sets the pending flag and the following edge registers the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | Request line per channel |
| sample_i | input | 1 | Strobe that closes the sampling window |
| cpu_done_i | input | 1 | CPU finished one bus access |
| xfer_done_i | input | 1 | Granted transfer finished |
| grant_o | output | NCH | One-hot channel grant |
| cpu_owns_o | output | 1 | CPU holds the bus |

## Verification
Each result has its own latency. A strobe makes its requests pending one edge later, and the grant is registered one edge after that (two edges in total). A transfer-done or a CPU-access pulse changes `grant_o` at the very next edge. The bench drives inputs just after a rising edge and reads outputs one time unit after the edge at which the result is due. It also reads in the cycles before that edge, to confirm nothing moves early. For windows that must stay quiet, such as the CPU gap or a missing strobe, it checks every cycle of the window and not only its end.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    parameter int unsigned ARB_CH = 4;

    typedef enum logic {
        BUS_CPU = 1'b0,
        BUS_DMA = 1'b1
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   cpu_ok;
    } owner_st_t;

    function automatic logic any_set(input logic [ARB_CH-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/dma_req_window.sv
module dma_req_window #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_i,
    input  logic           sample_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] pend_o
);
    logic [NCH-1:0] seen_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] arrive;

    // everything seen since the last strobe, plus this cycle
    assign arrive = seen_q | req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            pend_q <= '0;
        end else begin
            seen_q <= sample_i ? '0 : arrive;
            // a new sample wins over the clear of a granted channel
            pend_q <= (pend_q & ~clr_i) | (sample_i ? arrive : '0);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int unsigned NCH = 4
) (
    input  logic [NCH-1:0] pend_i,
    output logic [NCH-1:0] pick_o
);
    logic [NCH:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chain
            assign pick_o[i]    = pend_i[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | pend_i[i];
        end
    endgenerate
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
    import dma_arb_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pick_i,
    input  logic           cpu_done_i,
    input  logic           xfer_done_i,
    output logic [NCH-1:0] clr_o,
    output logic [NCH-1:0] grant_o,
    output logic           cpu_owns_o
);
    owner_st_t      st_q;
    logic [NCH-1:0] grant_q;
    logic           eligible;

    assign eligible = (st_q.owner == BUS_CPU) && (st_q.cpu_ok || cpu_done_i)
                      && (|pick_i);
    assign clr_o    = eligible ? pick_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.owner  <= BUS_CPU;
            st_q.cpu_ok <= 1'b1;
            grant_q     <= '0;
        end else begin
            unique case (st_q.owner)
                BUS_CPU: begin
                    if (eligible) begin
                        st_q.owner  <= BUS_DMA;
                        st_q.cpu_ok <= 1'b0;
                        grant_q     <= pick_i;
                    end else if (cpu_done_i) begin
                        st_q.cpu_ok <= 1'b1;
                    end
                end
                BUS_DMA: begin
                    if (xfer_done_i) begin
                        st_q.owner  <= BUS_CPU;
                        st_q.cpu_ok <= 1'b0;
                        grant_q     <= '0;
                    end
                end
                default: st_q.owner <= BUS_CPU;
            endcase
        end
    end

    assign grant_o    = grant_q;
    assign cpu_owns_o = (st_q.owner == BUS_CPU);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int unsigned NCH = ARB_CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_i,
    input  logic           sample_i,
    input  logic           cpu_done_i,
    input  logic           xfer_done_i,
    output logic [NCH-1:0] grant_o,
    output logic           cpu_owns_o
);
    logic [NCH-1:0] pend;
    logic [NCH-1:0] pick;
    logic [NCH-1:0] clr;

    dma_req_window #(.NCH(NCH)) win_i (
        .clk(clk), .rst(rst), .req_i(req_i), .sample_i(sample_i),
        .clr_i(clr), .pend_o(pend)
    );

    dma_prio_pick #(.NCH(NCH)) pick_i (
        .pend_i(pend), .pick_o(pick)
    );

    dma_bus_owner #(.NCH(NCH)) own_i (
        .clk(clk), .rst(rst), .pick_i(pick), .cpu_done_i(cpu_done_i),
        .xfer_done_i(xfer_done_i), .clr_o(clr), .grant_o(grant_o),
        .cpu_owns_o(cpu_owns_o)
    );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           cpu_done_i,
    input logic           xfer_done_i,
    input logic [NCH-1:0] grant_o,
    input logic           cpu_owns_o
);
    // set when a transfer ends, cleared by a CPU access while the CPU holds the bus
    logic gap_q;
    always_ff @(posedge clk) begin
        if (rst)                                gap_q <= 1'b0;
        else if ((|grant_o) && xfer_done_i)     gap_q <= 1'b1;
        else if (cpu_owns_o && cpu_done_i)      gap_q <= 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (grant_o == '0 && cpu_owns_o));

    assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    assert_owner_match_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_owns_o == (grant_o == '0));

    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ((|grant_o) && !xfer_done_i) |=> $stable(grant_o));

    assert_grant_release_R5: assert property (@(posedge clk) disable iff (rst)
        ((|grant_o) && xfer_done_i) |=> (grant_o == '0 && cpu_owns_o));

    assert_cpu_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_owns_o && gap_q && !cpu_done_i) |=> (grant_o == '0));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) chk_i (
    .clk(clk), .rst(rst), .cpu_done_i(cpu_done_i), .xfer_done_i(xfer_done_i),
    .grant_o(grant_o), .cpu_owns_o(cpu_owns_o)
);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb_top;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] req_i = '0;
    logic           sample_i = 1'b0;
    logic           cpu_done_i = 1'b0;
    logic           xfer_done_i = 1'b0;
    logic [NCH-1:0] grant_o;
    logic           cpu_owns_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_prio_arb #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .sample_i(sample_i),
        .cpu_done_i(cpu_done_i), .xfer_done_i(xfer_done_i),
        .grant_o(grant_o), .cpu_owns_o(cpu_owns_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        req_i = '0; sample_i = 1'b0; cpu_done_i = 1'b0; xfer_done_i = 1'b0;
    endtask

    task automatic check(input string tag, input logic [NCH-1:0] g_exp);
        total++;
        if (grant_o !== g_exp || cpu_owns_o !== (g_exp == '0)) begin
            bad++;
            $display("FAIL %s: grant=%b owns=%b expected grant=%b owns=%b",
                     tag, grant_o, cpu_owns_o, g_exp, (g_exp == '0));
        end
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic end_xfer();
        xfer_done_i = 1'b1; tick(); clear_in();
    endtask

    task automatic cpu_access();
        cpu_done_i = 1'b1; tick(); clear_in();
    endtask

    // R1, R10, R5: single request, latency, hold and release
    task automatic t_single();
        do_reset();
        check("R1 reset state", 4'b0000);
        req_i = 4'b0100; sample_i = 1'b1; tick(); clear_in();
        check("R10 no grant one cycle after strobe", 4'b0000);
        tick();
        check("R10 grant two cycles after strobe", 4'b0100);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R5 grant held", 4'b0100);
        end
        end_xfer();
        check("R5 release after done", 4'b0000);
    endtask

    // R2: request without a strobe stays unsampled until the strobe
    task automatic t_window();
        do_reset();
        req_i = 4'b0010; tick(); clear_in();
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R2 no strobe no grant", 4'b0000);
        end
        sample_i = 1'b1; tick(); clear_in(); tick();
        check("R2 earlier request taken at strobe", 4'b0010);
    endtask

    // R3, R7: priority order and CPU gap between transfers
    task automatic t_order();
        do_reset();
        req_i = 4'b1111; sample_i = 1'b1; tick(); clear_in(); tick();
        check("R3 channel 0 first", 4'b0001);
        for (int k = 1; k < NCH; k++) begin
            end_xfer();
            tick(); tick();
            check("R7 no grant before cpu access", 4'b0000);
            cpu_access();
            check("R3 next channel in order", 4'(1 << k));
        end
        end_xfer();
        cpu_access();
        check("R9 idle after all served", 4'b0000);
    endtask

    // R6: repeated requests merge; R3 lower channel overtakes
    task automatic t_merge();
        do_reset();
        req_i = 4'b1000; sample_i = 1'b1; tick(); clear_in(); tick();
        check("R6 ch3 granted", 4'b1000);
        req_i = 4'b0001; tick(); clear_in(); tick();
        req_i = 4'b0001; sample_i = 1'b1; tick(); clear_in();
        req_i = 4'b0001; sample_i = 1'b1; tick(); clear_in();
        check("R5 grant unchanged by other requests", 4'b1000);
        end_xfer();
        cpu_access();
        check("R6 merged ch0 granted", 4'b0001);
        end_xfer();
        cpu_access();
        check("R6 only one grant for merged requests", 4'b0000);
        tick(); tick();
        check("R6 still no second grant", 4'b0000);
    endtask

    // R8: own request during transfer re-arms the channel
    task automatic t_rearm();
        do_reset();
        req_i = 4'b0100; sample_i = 1'b1; tick(); clear_in(); tick();
        check("R8 first grant", 4'b0100);
        req_i = 4'b0100; sample_i = 1'b1; tick(); clear_in();
        end_xfer();
        cpu_access();
        check("R8 channel granted again", 4'b0100);
    endtask

    // R9: nothing pending, CPU keeps bus
    task automatic t_idle();
        do_reset();
        for (int k = 0; k < 4; k++) begin
            cpu_done_i = k[0]; xfer_done_i = ~k[0]; tick(); clear_in();
            check("R9 cpu keeps bus", 4'b0000);
        end
    endtask

    initial begin
        t_single();
        t_window();
        t_order();
        t_merge();
        t_rearm();
        t_idle();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule